// File: doc/BRIEF.md
# Timestamp-Matched One-Shot Trigger

This block produces a single trigger pulse at a moment chosen by software. A host programs a target time (a seconds value plus a coarse cycle count within the second) through a small word-addressed register interface, then sets an arm bit. The block watches a free-running local time presented on its time inputs, and on the first cycle where it is armed and the local time equals the target, it emits a one-cycle pulse and drops the arm bit by itself.

Because the host reads back the live armed state through the control register, firmware can poll that bit to learn whether the programmed moment has been reached. The target registers are full 64-bit and 32-bit read-write storage, but only the low 40 seconds bits and the low 28 cycle bits take part in the comparison, matching the width of the local time base. A target already in the past is never matched; the block then stays armed until the host clears the bit.

Top module: `tstamp_oneshot`

## Requirements
- R1: After reset every target register reads 0, the control register reads 0 and `trig_o` is low.
- R2: The 64-bit seconds target is held as two words: byte offset 0x08 holds bits 63..32 and byte offset 0x0C holds bits 31..0; each word reads back exactly what was last written to it.
- R3: The 32-bit cycle target at byte offset 0x10 reads back exactly what was last written.
- R4: The control register is at byte offset 0x00 with the arm bit at bit 0; a write takes effect at the clock edge that samples the write, and a read right after arming returns 0x00000001 (all other bits read 0).
- R5: `trig_o` is high for exactly one cycle, in the cycle that follows the first clock edge at which the block is armed and the local time equals the target.
- R6: Only target seconds bits 39..0 are compared with `now_sec_i` and only cycle target bits 27..0 with `now_cyc_i`; the upper 24 and 4 bits have no effect on firing.
- R7: Firing clears the arm bit: afterwards the control register reads 0 and no further pulse occurs while the time stays equal to the target.
- R8: Arming while the local time already equals the target fires one cycle after the arm takes effect.
- R9: While disarmed no pulse is produced even if the time matches; a target already passed when arming never fires and the arm bit stays 1 until the host writes 0.
- R10: When a control write lands on the same edge as a firing, the pulse is still produced and the armed state takes the written value.
- R11: Writes to unmapped or misaligned addresses change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_i | input | 1 | One-cycle register write request |
| reg_addr_i | input | 5 | Byte address of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| now_sec_i | input | 40 | Current seconds of the local time base |
| now_cyc_i | input | 28 | Current coarse cycle count within the second |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The host's control write and the self-clearing of the arm bit on a match can land on the same clock edge, and both act on the one armed flag. The bench provokes this by presenting the matching time and a control write in the same cycle, once writing 0 and once writing 1. It then judges that the pulse still appears in the scoreboard's expected cycle and that the control register read afterwards reflects the written value rather than the automatic clear.

// File: rtl/tso_pkg.sv
package tso_pkg;
  // Register layout, byte offsets on a 4-byte word grid.
  localparam int unsigned REG_BYTES = 4;
  localparam int unsigned OFS_CTRL  = 0;
  localparam int unsigned OFS_SEC   = 8;   // first word: most significant half
  localparam int unsigned OFS_CYC   = 16;
  localparam int unsigned ARM_BIT   = 0;
endpackage

// File: rtl/tso_rst_sync.sv
module tso_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/tso_regfile.sv
module tso_regfile
  import tso_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned SEC_W     = 64,
  parameter int unsigned CYC_W     = 32,
  parameter int unsigned SEC_CMP_W = 40,
  parameter int unsigned CYC_CMP_W = 28
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 armed_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 ctrl_stb_o,
  output logic                 ctrl_arm_o,
  output logic [SEC_CMP_W-1:0] tgt_sec_o,
  output logic [CYC_CMP_W-1:0] tgt_cyc_o
);
  localparam int unsigned WA_W      = ADDR_W - 2;
  localparam int unsigned SEC_WORDS = SEC_W / DATA_W;
  localparam int unsigned CTRL_IDX  = OFS_CTRL / REG_BYTES;
  localparam int unsigned SEC_IDX   = OFS_SEC / REG_BYTES;
  localparam int unsigned CYC_IDX   = OFS_CYC / REG_BYTES;

  logic [WA_W-1:0]  wa;
  logic             aligned;
  logic [SEC_W-1:0] sec_flat;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic             cyc_en;

  assign wa      = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  // Seconds target: one storage word per generate slot, top word first.
  for (genvar gi = 0; gi < SEC_WORDS; gi++) begin : g_sec
    logic              en;
    logic [DATA_W-1:0] d, q;

    always_comb begin
      en = wr_i && aligned && (wa == WA_W'(SEC_IDX + gi));
      d  = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (en)  q <= d;
    end

    assign sec_flat[SEC_W-1-gi*DATA_W -: DATA_W] = q;
  end

  // Cycle target
  always_comb begin
    cyc_en = wr_i && aligned && (wa == WA_W'(CYC_IDX));
    cyc_d  = wdata_i[CYC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cyc_q <= '0;
    else if (cyc_en) cyc_q <= cyc_d;
  end

  // Control write strobe, one cycle per host write
  always_comb begin
    ctrl_stb_o = wr_i && aligned && (wa == WA_W'(CTRL_IDX));
    ctrl_arm_o = wdata_i[ARM_BIT];
  end

  // Read mux
  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      if (wa == WA_W'(CTRL_IDX)) rdata_o[ARM_BIT] = armed_i;
      if (wa == WA_W'(CYC_IDX))  rdata_o[CYC_W-1:0] = cyc_q;
      for (int i = 0; i < SEC_WORDS; i++) begin
        if (wa == WA_W'(SEC_IDX + i)) rdata_o = sec_flat[SEC_W-1-i*DATA_W -: DATA_W];
      end
    end
  end

  assign tgt_sec_o = sec_flat[SEC_CMP_W-1:0];
  assign tgt_cyc_o = cyc_q[CYC_CMP_W-1:0];

  // R2: seconds storage moves only on a host write
  a_r2_sec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(sec_flat));

  // R3: cycle target captures the written word
  a_r3_cyc_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(OFS_CYC)) |=> (cyc_q == $past(wdata_i[CYC_W-1:0])));

  // R11: misaligned accesses leave all storage untouched
  a_r11_misaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[1:0] != 2'b00) |=> ($stable(sec_flat) && $stable(cyc_q)));
endmodule

// File: rtl/tso_match.sv
module tso_match #(
  parameter int unsigned SEC_CMP_W = 40,
  parameter int unsigned CYC_CMP_W = 28
) (
  input  logic [SEC_CMP_W-1:0] tgt_sec_i,
  input  logic [CYC_CMP_W-1:0] tgt_cyc_i,
  input  logic [SEC_CMP_W-1:0] now_sec_i,
  input  logic [CYC_CMP_W-1:0] now_cyc_i,
  output logic                 hit_o
);
  logic sec_eq, cyc_eq;

  always_comb begin
    sec_eq = (tgt_sec_i == now_sec_i);
    cyc_eq = (tgt_cyc_i == now_cyc_i);
    hit_o  = sec_eq && cyc_eq;
  end
endmodule

// File: rtl/tso_fire.sv
module tso_fire (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_stb_i,
  input  logic ctrl_arm_i,
  input  logic hit_i,
  output logic armed_o,
  output logic trig_o
);
  logic armed_q, armed_d, armed_en;
  logic trig_q, fire_d;

  // Next state: host write has priority over the self-clear.
  always_comb begin
    fire_d   = armed_q && hit_i;
    armed_en = ctrl_stb_i || fire_d;
    armed_d  = ctrl_stb_i ? ctrl_arm_i : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= fire_d;
  end

  assign armed_o = armed_q;
  assign trig_o  = trig_q;

  // R4: the arm bit only rises through a host write of 1
  a_r4_arm_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(ctrl_stb_i && ctrl_arm_i));

  // R5: a pulse always comes from an armed state
  a_r5_fire_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |-> $past(armed_q));

  // R5: pulse lasts one cycle unless the host re-armed on the firing edge
  a_r5_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && !$past(ctrl_stb_i)) |=> !trig_q);

  // R7: a match while armed and undisturbed fires and disarms
  a_r7_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && hit_i && !ctrl_stb_i) |=> (trig_q && !armed_q));

  // R9: nothing fires from a disarmed state
  a_r9_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> !trig_q);

  // R10: a control write decides the armed state even on a firing edge
  a_r10_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_stb_i |=> (armed_q == $past(ctrl_arm_i)));
endmodule

// File: rtl/tstamp_oneshot.sv
module tstamp_oneshot #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned SEC_W     = 64,
  parameter int unsigned CYC_W     = 32,
  parameter int unsigned SEC_CMP_W = 40,
  parameter int unsigned CYC_CMP_W = 28
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic [SEC_CMP_W-1:0] now_sec_i,
  input  logic [CYC_CMP_W-1:0] now_cyc_i,
  output logic                 trig_o
);
  logic                 rst_n;
  logic                 ctrl_stb, ctrl_arm, armed, hit;
  logic [SEC_CMP_W-1:0] tgt_sec;
  logic [CYC_CMP_W-1:0] tgt_cyc;

  tso_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  tso_regfile #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEC_W(SEC_W), .CYC_W(CYC_W),
    .SEC_CMP_W(SEC_CMP_W), .CYC_CMP_W(CYC_CMP_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .armed_i    (armed),
    .rdata_o    (reg_rdata_o),
    .ctrl_stb_o (ctrl_stb),
    .ctrl_arm_o (ctrl_arm),
    .tgt_sec_o  (tgt_sec),
    .tgt_cyc_o  (tgt_cyc)
  );

  tso_match #(.SEC_CMP_W(SEC_CMP_W), .CYC_CMP_W(CYC_CMP_W)) u_match (
    .tgt_sec_i (tgt_sec),
    .tgt_cyc_i (tgt_cyc),
    .now_sec_i (now_sec_i),
    .now_cyc_i (now_cyc_i),
    .hit_o     (hit)
  );

  tso_fire u_fire (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .ctrl_stb_i (ctrl_stb),
    .ctrl_arm_i (ctrl_arm),
    .hit_i      (hit),
    .armed_o    (armed),
    .trig_o     (trig_o)
  );
endmodule

// File: tb/tstamp_oneshot_test.sv
module tstamp_oneshot_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [39:0] now_sec = '0;
  logic [27:0] now_cyc = '0;
  logic        trig;

  int unsigned cyc = 0;
  int unsigned checks = 0;
  int unsigned fails = 0;
  bit          done = 1'b0;
  int unsigned exp_q[$];

  localparam logic [4:0]  A_CTRL = 5'h00, A_SHI = 5'h08, A_SLO = 5'h0C, A_CYC = 5'h10;
  localparam logic [39:0] T_SEC = 40'h12_0000_5A34;
  localparam logic [27:0] T_CYC = 28'h000_1000;

  tstamp_oneshot uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .now_sec_i(now_sec),
    .now_cyc_i(now_cyc), .trig_o(trig)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Driver: register write; optional expected pulse two edges later
  task automatic reg_write(logic [4:0] a, logic [31:0] d, bit expect_fire);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    if (expect_fire) exp_q.push_back(cyc + 2);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_check(string req, logic [4:0] a, logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  // Driver: move the local time; optional expected pulse one edge later
  task automatic set_time(logic [39:0] s, logic [27:0] c, bit expect_fire);
    @(negedge clk);
    now_sec = s; now_cyc = c;
    if (expect_fire) exp_q.push_back(cyc + 1);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares trig against the scoreboard each cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          void'(exp_q.pop_front());
          chk("R5 pulse in expected cycle", {31'b0, trig}, 32'h1);
        end else if (exp_q.size() > 0 && exp_q[0] < cyc) begin
          void'(exp_q.pop_front());
          chk("R5 expected pulse missed", 32'h0, 32'h1);
        end else if (trig) begin
          chk("R9 unexpected pulse", 32'h1, 32'h0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state (time 0 equals reset target but block is disarmed)
    reg_check("R1 ctrl", A_CTRL, 32'h0);
    reg_check("R1 sec hi", A_SHI, 32'h0);
    reg_check("R1 sec lo", A_SLO, 32'h0);
    reg_check("R1 cyc", A_CYC, 32'h0);
    chk("R1 trig low", {31'b0, trig}, 32'h0);

    // R2 / R3: target storage, upper bits nonzero to exercise R6
    reg_write(A_SHI, 32'hAABB_CC12, 1'b0);
    reg_write(A_SLO, 32'h0000_5A34, 1'b0);
    reg_write(A_CYC, 32'hF000_1000, 1'b0);
    reg_check("R2 sec hi word", A_SHI, 32'hAABB_CC12);
    reg_check("R2 sec lo word", A_SLO, 32'h0000_5A34);
    reg_check("R3 cyc word", A_CYC, 32'hF000_1000);

    // R11: unmapped and misaligned accesses
    reg_write(5'h04, 32'hFFFF_FFFF, 1'b0);
    reg_write(5'h0A, 32'h1234_5678, 1'b0);
    reg_write(5'h11, 32'h0BAD_0BAD, 1'b0);
    reg_check("R11 unmapped reads 0", 5'h04, 32'h0);
    reg_check("R11 unmapped high reads 0", 5'h14, 32'h0);
    reg_check("R11 misaligned reads 0", 5'h0D, 32'h0);
    reg_check("R11 sec hi untouched", A_SHI, 32'hAABB_CC12);
    reg_check("R11 cyc untouched", A_CYC, 32'hF000_1000);
    reg_check("R11 ctrl untouched", A_CTRL, 32'h0);

    // R4: arm with time short of target
    set_time(T_SEC - 1, T_CYC, 1'b0);
    reg_write(A_CTRL, 32'h0000_0001, 1'b0);
    reg_check("R4 readback after arm", A_CTRL, 32'h1);

    // R5 / R6: time reaches target (upper target bits ignored)
    set_time(T_SEC, T_CYC - 1, 1'b0);
    set_time(T_SEC, T_CYC, 1'b1);
    idle(3);
    // R7: disarmed, time held at target, no repeat
    reg_check("R7 ctrl cleared after fire", A_CTRL, 32'h0);
    idle(3);

    // R8: re-arm while time already equals target
    reg_write(A_CTRL, 32'h0000_0001, 1'b1);
    idle(3);
    reg_check("R8 ctrl cleared after re-arm fire", A_CTRL, 32'h0);

    // R9: disarm before match
    set_time(T_SEC, T_CYC + 5, 1'b0);
    reg_write(A_CTRL, 32'h0000_0001, 1'b0);
    reg_write(A_CTRL, 32'h0000_0000, 1'b0);
    set_time(T_SEC, T_CYC, 1'b0);
    idle(4);
    reg_check("R9 stays disarmed", A_CTRL, 32'h0);

    // R9: target already in the past
    set_time(T_SEC + 1, 28'h0, 1'b0);
    reg_write(A_CTRL, 32'h0000_0001, 1'b0);
    for (int i = 1; i < 6; i++) set_time(T_SEC + 1, 28'(i), 1'b0);
    reg_check("R9 past target stays armed", A_CTRL, 32'h1);
    reg_write(A_CTRL, 32'h0000_0000, 1'b0);
    reg_check("R9 host clears arm", A_CTRL, 32'h0);

    // R10: control write of 0 on the firing edge
    set_time(T_SEC - 1, T_CYC, 1'b0);
    reg_write(A_CTRL, 32'h0000_0001, 1'b0);
    @(negedge clk);
    now_sec = T_SEC; now_cyc = T_CYC;
    wr = 1'b1; addr = A_CTRL; wdata = 32'h0;
    exp_q.push_back(cyc + 1);
    @(negedge clk);
    wr = 1'b0; now_cyc = T_CYC + 1;
    reg_check("R10 write 0 on fire edge", A_CTRL, 32'h0);

    // R10: control write of 1 on the firing edge
    set_time(T_SEC - 1, T_CYC, 1'b0);
    reg_write(A_CTRL, 32'h0000_0001, 1'b0);
    @(negedge clk);
    now_sec = T_SEC; now_cyc = T_CYC;
    wr = 1'b1; addr = A_CTRL; wdata = 32'h1;
    exp_q.push_back(cyc + 1);
    @(negedge clk);
    wr = 1'b0; now_cyc = T_CYC + 1;
    reg_check("R10 write 1 on fire edge", A_CTRL, 32'h1);
    reg_write(A_CTRL, 32'h0000_0000, 1'b0);

    idle(5);
    chk("R5 scoreboard drained", exp_q.size(), 32'h0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule